// File: doc/BRIEF.md
# Instruction Prefetch Queue

This block fetches instruction words ahead of execution and keeps them in a small register-built first-in first-out queue. It has its own fetch address. It sends one-word read requests to an instruction memory port, with a valid/ready handshake on the request and in-order responses. Fetching goes on in parallel with execution for as long as the queue and the requests already in flight leave room for another word.

The execute stage takes the oldest queued word through a valid/ready handshake. Each word comes with the address it was fetched from, so that branch targets can be computed from it.

When the execute stage reports a taken branch, the block:
- drops every queued word;
- marks every response still in flight as stale, so it is thrown away on arrival;
- loads the fetch address with the branch target;
- sends the next request from that target.

Top module: `instr_prefetch_queue`

## Requirements
- R1: While reset is held and before the first clock edge after release, `out_valid` is 0, `req_valid` is 1 and `req_addr` equals the parameter `RESET_ADDR` (default 0).
- R2: Each accepted request (`req_valid` and `req_ready` both 1 at a rising edge) advances the fetch address by exactly one word. `req_addr` in the next cycle is the accepted address plus one.
- R3: Queued words plus outstanding requests (stale ones included) never exceed `DEPTH`. With the consumer stalled, exactly `DEPTH` requests are accepted after a flush.
- R4: Words are presented in the order they were requested. `out_pc` is the fetch address of the word, and `out_instr` is the memory data returned for that address.
- R5: While `out_valid` is 1 and `out_ready` is 0 (and no flush), `out_valid`, `out_instr` and `out_pc` hold their values into the next cycle.
- R6: In the cycle after a cycle with `br_taken` = 1, `out_valid` is 0, because every queued word has been dropped. A handshake in the flush cycle itself does not consume a word.
- R7: In a cycle with `br_taken` = 1, `req_valid` is 0. The next request carries `br_target` from the last flush cycle, and when two flushes are back to back the later target wins.
- R8: Responses for requests accepted before a flush, including one arriving in the flush cycle, are discarded. The first word delivered after a flush is the one at the branch target.
- R9: With memory and consumer always ready, once the pipeline has filled the block delivers at least 16 words in any 20 consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | output | 1 | Fetch request valid |
| req_ready | input | 1 | Memory accepts the request |
| req_addr | output | AW | Word address of the fetch |
| rsp_valid | input | 1 | Memory returns a word, in request order |
| rsp_data | input | INSTR_W | Returned instruction word |
| out_valid | output | 1 | Oldest queued word is available |
| out_ready | input | 1 | Execute stage takes the word |
| out_instr | output | INSTR_W | Oldest queued instruction word |
| out_pc | output | AW | Fetch address of `out_instr` |
| br_taken | input | 1 | Taken branch: flush and redirect |
| br_target | input | AW | New fetch address on a flush |

## Verification
Timing of each result, counted from the stimulus:
- `req_addr` and `req_valid` respond in the same cycle, and the advanced address of R2 appears one edge after acceptance.
- A kept response shows at the queue head one edge after it arrives.
- A flush shows as `out_valid` = 0 one edge later, and the first request of the new path is due in the very next cycle.

The bench drives inputs just after the falling edge and samples one nanosecond later, so each check sees the state that the coming rising edge will act on. A scoreboard queue, filled with independently computed addresses at each accepted request and emptied at each flush, gives the expected address and data for every delivered word.

// File: rtl/pfq_pkg.sv
package pfq_pkg;

  // True when one more request still fits beside what is queued and pending.
  function automatic logic credit_ok(input int unsigned queued,
                                     input int unsigned pend,
                                     input int unsigned depth);
    return (queued + pend) < depth;
  endfunction

  // Circular index step for a ring of the given size.
  function automatic int unsigned ring_next(input int unsigned idx,
                                            input int unsigned depth);
    return (idx + 1 == depth) ? 0 : idx + 1;
  endfunction

endpackage

// File: rtl/pfq_fifo.sv
module pfq_fifo #(
  parameter int DW    = 48,
  parameter int DEPTH = 4,
  localparam int IXW  = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          push,
  input  logic [DW-1:0] push_data,
  input  logic          pop,
  output logic [DW-1:0] head,
  output logic          empty,
  output logic [CW-1:0] level
);

  logic [DW-1:0]  slot [DEPTH];
  logic [IXW-1:0] wr_idx, rd_idx;
  logic [CW-1:0]  cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_idx <= '0;
      rd_idx <= '0;
      cnt    <= '0;
    end else if (clr) begin
      wr_idx <= '0;
      rd_idx <= '0;
      cnt    <= '0;
    end else begin
      if (push) wr_idx <= IXW'(pfq_pkg::ring_next(int'(wr_idx), DEPTH));
      if (pop)  rd_idx <= IXW'(pfq_pkg::ring_next(int'(rd_idx), DEPTH));
      if (push && !pop)      cnt <= cnt + 1'b1;
      else if (pop && !push) cnt <= cnt - 1'b1;
    end
  end

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    always_ff @(posedge clk) begin
      if (push && !clr && wr_idx == IXW'(g)) slot[g] <= push_data;
    end
  end

  assign head  = slot[rd_idx];
  assign empty = (cnt == '0);
  assign level = cnt;

endmodule

// File: rtl/pfq_track.sv
module pfq_track #(
  parameter int DEPTH = 4,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          issue,
  input  logic          resp,
  input  logic          flush,
  output logic          keep,
  output logic [CW-1:0] pend,
  output logic [CW-1:0] stale
);

  logic [CW-1:0] pend_nxt;

  always_comb begin
    pend_nxt = pend;
    if (issue) pend_nxt = pend_nxt + 1'b1;
    if (resp)  pend_nxt = pend_nxt - 1'b1;
  end

  // A response is kept only when no stale one is ahead of it.
  assign keep = resp && !flush && (stale == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend  <= '0;
      stale <= '0;
    end else begin
      pend <= pend_nxt;
      if (flush)                     stale <= pend_nxt;
      else if (resp && stale != '0)  stale <= stale - 1'b1;
    end
  end

endmodule

// File: rtl/pfq_fetch.sv
module pfq_fetch #(
  parameter int            AW         = 16,
  parameter logic [AW-1:0] RESET_ADDR = '0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          flush,
  input  logic [AW-1:0] target,
  input  logic          fire,
  input  logic          keep,
  output logic [AW-1:0] fetch_ptr,
  output logic [AW-1:0] rsp_pc
);

  function automatic logic [AW-1:0] word_step(input logic [AW-1:0] a);
    return a + 1'b1;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fetch_ptr <= RESET_ADDR;
      rsp_pc    <= RESET_ADDR;
    end else if (flush) begin
      fetch_ptr <= target;
      rsp_pc    <= target;
    end else begin
      if (fire) fetch_ptr <= word_step(fetch_ptr);
      if (keep) rsp_pc    <= word_step(rsp_pc);
    end
  end

endmodule

// File: rtl/instr_prefetch_queue.sv
module instr_prefetch_queue #(
  parameter int            AW         = 16,
  parameter int            INSTR_W    = 32,
  parameter int            DEPTH      = 4,
  parameter logic [AW-1:0] RESET_ADDR = '0
) (
  input  logic               clk,
  input  logic               rst_n,
  output logic               req_valid,
  input  logic               req_ready,
  output logic [AW-1:0]      req_addr,
  input  logic               rsp_valid,
  input  logic [INSTR_W-1:0] rsp_data,
  output logic               out_valid,
  input  logic               out_ready,
  output logic [INSTR_W-1:0] out_instr,
  output logic [AW-1:0]      out_pc,
  input  logic               br_taken,
  input  logic [AW-1:0]      br_target
);

  localparam int CW = $clog2(DEPTH + 1);
  localparam int EW = AW + INSTR_W;

  logic [CW-1:0] level, pend, stale_cnt;
  logic          rsp_keep, req_fire, pop, empty;
  logic [AW-1:0] fetch_ptr, rsp_pc;
  logic [EW-1:0] head;

  assign req_valid = !br_taken && pfq_pkg::credit_ok(int'(level), int'(pend), DEPTH);
  assign req_addr  = fetch_ptr;
  assign req_fire  = req_valid && req_ready;
  assign out_valid = !empty;
  assign pop       = out_valid && out_ready && !br_taken;
  assign out_pc    = head[EW-1:INSTR_W];
  assign out_instr = head[INSTR_W-1:0];

  pfq_fetch #(.AW(AW), .RESET_ADDR(RESET_ADDR)) fetch_i (
    .clk(clk), .rst_n(rst_n), .flush(br_taken), .target(br_target),
    .fire(req_fire), .keep(rsp_keep), .fetch_ptr(fetch_ptr), .rsp_pc(rsp_pc)
  );

  pfq_track #(.DEPTH(DEPTH)) track_i (
    .clk(clk), .rst_n(rst_n), .issue(req_fire), .resp(rsp_valid),
    .flush(br_taken), .keep(rsp_keep), .pend(pend), .stale(stale_cnt)
  );

  pfq_fifo #(.DW(EW), .DEPTH(DEPTH)) fifo_i (
    .clk(clk), .rst_n(rst_n), .clr(br_taken), .push(rsp_keep),
    .push_data({rsp_pc, rsp_data}), .pop(pop), .head(head),
    .empty(empty), .level(level)
  );

endmodule

// File: rtl/pfq_checker.sv
module pfq_checker #(
  parameter int AW      = 16,
  parameter int INSTR_W = 32,
  parameter int DEPTH   = 4,
  localparam int CW     = $clog2(DEPTH + 1)
) (
  input logic               clk,
  input logic               rst_n,
  input logic               br_taken,
  input logic [AW-1:0]      br_target,
  input logic               req_valid,
  input logic               req_ready,
  input logic [AW-1:0]      req_addr,
  input logic               out_valid,
  input logic               out_ready,
  input logic [INSTR_W-1:0] out_instr,
  input logic [AW-1:0]      out_pc,
  input logic [CW-1:0]      level,
  input logic [CW-1:0]      pend,
  input logic [CW-1:0]      stale_cnt
);

  a_r2_addr_step: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready |=> req_addr == $past(req_addr) + 1'b1);

  a_r3_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(level) + int'(pend)) <= DEPTH);

  a_r8_stale_within_pend: assert property (@(posedge clk) disable iff (!rst_n)
    stale_cnt <= pend);

  a_r4_pc_order: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_ready && !br_taken |=> !out_valid || out_pc == $past(out_pc) + 1'b1);

  a_r5_hold: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready && !br_taken |=>
      out_valid && $stable(out_pc) && $stable(out_instr));

  a_r6_empty_after_flush: assert property (@(posedge clk) disable iff (!rst_n)
    br_taken |=> !out_valid);

  a_r7_no_req_on_flush: assert property (@(posedge clk) disable iff (!rst_n)
    br_taken |-> !req_valid);

  a_r7_restart_addr: assert property (@(posedge clk) disable iff (!rst_n)
    br_taken |=> req_addr == $past(br_target));

endmodule

bind instr_prefetch_queue pfq_checker #(.AW(AW), .INSTR_W(INSTR_W), .DEPTH(DEPTH)) chk_i (
  .clk(clk), .rst_n(rst_n), .br_taken(br_taken), .br_target(br_target),
  .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
  .out_valid(out_valid), .out_ready(out_ready), .out_instr(out_instr),
  .out_pc(out_pc), .level(level), .pend(pend), .stale_cnt(stale_cnt)
);

// File: tb/instr_prefetch_queue_tb_top.sv
module instr_prefetch_queue_tb_top;

  localparam int AW      = 16;
  localparam int INSTR_W = 32;
  localparam int DEPTH   = 4;

  logic               clk = 1'b0;
  logic               rst_n = 1'b0;
  logic               req_valid, req_ready = 1'b0;
  logic [AW-1:0]      req_addr;
  logic               rsp_valid;
  logic [INSTR_W-1:0] rsp_data;
  logic               out_valid, out_ready = 1'b0;
  logic [INSTR_W-1:0] out_instr;
  logic [AW-1:0]      out_pc;
  logic               br_taken = 1'b0;
  logic [AW-1:0]      br_target = '0;

  int checks = 0;
  int bad    = 0;
  int fires  = 0;
  int xfers  = 0;
  logic [AW-1:0] exp_req = '0;
  logic [AW-1:0] exp_q [$];
  bit            flush_prev = 1'b0;

  always #2 clk = ~clk;

  instr_prefetch_queue #(.AW(AW), .INSTR_W(INSTR_W), .DEPTH(DEPTH)) dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .rsp_valid(rsp_valid), .rsp_data(rsp_data),
    .out_valid(out_valid), .out_ready(out_ready), .out_instr(out_instr),
    .out_pc(out_pc), .br_taken(br_taken), .br_target(br_target)
  );

  function automatic logic [INSTR_W-1:0] instr_of(input logic [AW-1:0] a);
    return {a ^ 16'hA5C3, ~a};
  endfunction

  // Memory model: two-cycle in-order read pipeline.
  logic          m0_v, m1_v;
  logic [AW-1:0] m0_a, m1_a;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m0_v <= 1'b0; m1_v <= 1'b0; m0_a <= '0; m1_a <= '0;
    end else begin
      m0_v <= req_valid && req_ready;
      m0_a <= req_addr;
      m1_v <= m0_v;
      m1_a <= m0_a;
    end
  end
  assign rsp_valid = m1_v;
  assign rsp_data  = instr_of(m1_a);

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h at %0t", req, act, exp, $time);
    end
  endtask

  // Driver and scoreboard monitor for one clock cycle.
  task automatic step(input logic ordy, input logic mrdy, input logic br, input logic [AW-1:0] tgt);
    logic [AW-1:0] e;
    @(negedge clk);
    out_ready = ordy; req_ready = mrdy; br_taken = br; br_target = tgt;
    #1;
    if (flush_prev) check(!out_valid, "R6 queue empty after flush", out_valid, 0);
    flush_prev = br;
    if (br) check(!req_valid, "R7 no request in flush cycle", req_valid, 0);
    if (req_valid && req_ready) begin
      check(req_addr == exp_req, "R2 R7 request address", req_addr, exp_req);
      exp_q.push_back(exp_req);
      exp_req = exp_req + 1'b1;
      fires++;
    end
    if (out_valid && out_ready && !br) begin
      xfers++;
      if (exp_q.size() == 0) begin
        check(1'b0, "R4 R8 unexpected delivery", out_pc, 0);
      end else begin
        e = exp_q.pop_front();
        check(out_pc == e, "R4 R8 delivered pc", out_pc, e);
        check(out_instr == instr_of(e), "R4 delivered data", out_instr, instr_of(e));
      end
    end
    if (br) begin
      exp_q.delete();
      exp_req = tgt;
    end
  endtask

  initial begin : watchdog
    repeat (50000) @(posedge clk);
    bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end

  initial begin : main
    logic [15:0]   lfsr;
    logic [AW-1:0] held_pc;
    int            base;
    #1;
    check(!out_valid, "R1 reset out_valid", out_valid, 0);
    check(req_valid, "R1 reset req_valid", req_valid, 1);
    check(req_addr == '0, "R1 reset req_addr", req_addr, 0);
    repeat (2) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    check(req_valid && req_addr == '0, "R1 first request at reset address", req_addr, 0);

    // Streaming at full rate (R9, R4).
    for (int i = 0; i < 10; i++) step(1'b1, 1'b1, 1'b0, '0);
    base = xfers;
    for (int i = 0; i < 20; i++) step(1'b1, 1'b1, 1'b0, '0);
    check(xfers - base >= 16, "R9 throughput in 20 cycles", xfers - base, 16);

    // Flush mid-stream with responses in flight (R6, R7, R8).
    step(1'b1, 1'b1, 1'b1, 16'h0100);
    for (int i = 0; i < 12; i++) step(1'b1, 1'b1, 1'b0, '0);

    // Flush, then stall the consumer: exactly DEPTH requests (R3), head held (R5).
    step(1'b1, 1'b1, 1'b1, 16'h0200);
    base = fires;
    for (int i = 0; i < 14; i++) step(1'b0, 1'b1, 1'b0, '0);
    check(fires - base == DEPTH, "R3 requests after flush with stalled consumer", fires - base, DEPTH);
    check(out_valid && out_pc == 16'h0200, "R8 head is branch target", out_pc, 16'h0200);
    held_pc = out_pc;
    for (int i = 0; i < 3; i++) begin
      step(1'b0, 1'b1, 1'b0, '0);
      check(out_valid && out_pc == held_pc, "R5 head held while stalled", out_pc, held_pc);
      check(out_instr == instr_of(held_pc), "R5 data held while stalled", out_instr, instr_of(held_pc));
    end
    for (int i = 0; i < 10; i++) step(1'b1, 1'b1, 1'b0, '0);

    // Back-to-back flushes: later target wins (R7).
    step(1'b1, 1'b1, 1'b1, 16'h0300);
    step(1'b1, 1'b1, 1'b1, 16'h0400);
    step(1'b1, 1'b1, 1'b0, '0);
    check(req_valid && req_addr == 16'h0400, "R7 second target used", req_addr, 16'h0400);
    for (int i = 0; i < 10; i++) step(1'b1, 1'b1, 1'b0, '0);

    // Flush while memory stalls, then address wrap.
    step(1'b1, 1'b0, 1'b1, 16'hFFFE);
    for (int i = 0; i < 12; i++) step(1'b1, 1'b1, 1'b0, '0);

    // Irregular handshakes on both sides with periodic flushes.
    lfsr = 16'hACE1;
    for (int i = 0; i < 600; i++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      step(lfsr[0] | lfsr[3], lfsr[5] | lfsr[1], (i % 37) == 36, lfsr ^ 16'h1357);
    end
    for (int i = 0; i < 12; i++) step(1'b1, 1'b1, 1'b0, '0);

    $display("test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end

endmodule